// File: doc/BRIEF.md
# GPIO Bank Array with Per-Pin Interrupt Detection

A set of general-purpose I/O banks reached over a simple register bus (byte address, write strobe, write data, combinational read data). Each bank serves 32 pins. For every pin software chooses the direction, sets the driven value and reads back the synchronized input level. Several banks share the bus at a fixed 0x200-byte stride, so pin n lives in bit (n mod 32) of bank (n / 32).

Every pin can flag an interrupt on a rising edge, a falling edge, either edge, an active-high level or an active-low level. Three per-pin bit registers choose the trigger: a level/edge select, a dual-edge enable and a polarity bit. A flagged event latches into a raw status bit. A masked view (raw AND enable) is readable separately. A write-1-to-clear register drops status bits, so a handler can acknowledge a pin before servicing it. One registered interrupt line reports whether any enabled status bit is set in any bank.

Top module: `gpio_irq_banks`

## Requirements
- R1: Reset clears every register; during and right after reset all readable registers return 0, `pin_oe` is 0 and `irq_out` is 0.
- R2: Offset 0x04 holds the output value and offset 0x08 the output enable (1 = output), both read back as written; `pin_out` carries the output bit only where the enable bit is 1, else 0.
- R3: Offset 0x00 returns the pin inputs after a two-flop synchronizer, so a change driven before clock edge k reads back after edge k+1; writes to 0x00 are ignored.
- R4: With the level/edge select (0x0C) bit at 0 and dual-edge (0x10) bit at 0, a polarity (0x14) bit of 1 latches status on a rising edge only, and 0 on a falling edge only; status is visible at 0x1C after the third clock edge following the pin change.
- R5: With the dual-edge bit set in edge mode, both rising and falling edges latch status regardless of the polarity bit.
- R6: With the level/edge select bit at 1, status is set on every cycle the pin matches the polarity (1 = high, 0 = low), so a clear does not stick while the level is active.
- R7: Offset 0x18 is the interrupt enable (1 = enabled); offset 0x20 reads raw status (0x1C) AND enable; writes to 0x1C and 0x20 are ignored.
- R8: Writing 1 to a bit of offset 0x24 clears that status bit, writing 0 leaves it; 0x24 reads as 0; a new event in the same cycle as its clear leaves the bit set.
- R9: `irq_out` is the OR of all enabled status bits of all banks, registered: it changes one clock edge after the status change.
- R10: Bank b occupies byte addresses b*0x200 to b*0x200+0x24; pin n maps to bit (n mod 32) of bank (n / 32) and banks do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Byte address: bank index above the stride, register offset below |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| pin_in | input | NUM_BANKS*32 | Pin input levels, asynchronous |
| pin_out | output | NUM_BANKS*32 | Driven pin value, 0 where not enabled |
| pin_oe | output | NUM_BANKS*32 | Pin output enable, 1 = drive |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
A status bit stuck at 1 shows in the raw status read at once and, when enabled, raises `irq_out` one edge later where none should be; a lost or wrong previous-sample register shows as a missing or spurious status bit three edges after a pin change. A synchronizer of the wrong depth shifts the input-data read by a cycle, which the bench samples on both sides of the expected edge. A clear that acts on zero bits, or on the wrong bank, shows up on the next read of the other pins' status.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

   // Register select decoded from the byte offset inside one bank.
   typedef enum logic [3:0] {
      SEL_DIN,
      SEL_DOUT,
      SEL_OE,
      SEL_LVL,
      SEL_DUAL,
      SEL_POL,
      SEL_MASK,
      SEL_RAW,
      SEL_MSTAT,
      SEL_CLR,
      SEL_NONE
   } reg_sel_e;

   // Offsets are fixed because software and the bench decode them.
   function automatic reg_sel_e decode_off(input int unsigned off);
      case (off)
         32'h00:  return SEL_DIN;
         32'h04:  return SEL_DOUT;
         32'h08:  return SEL_OE;
         32'h0C:  return SEL_LVL;
         32'h10:  return SEL_DUAL;
         32'h14:  return SEL_POL;
         32'h18:  return SEL_MASK;
         32'h1C:  return SEL_RAW;
         32'h20:  return SEL_MSTAT;
         32'h24:  return SEL_CLR;
         default: return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin : p_param
      assert (STAGES >= 2) else $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] s,        // synchronized pin level
   input  logic [W-1:0] lvl_sel,  // 1 = level sensing
   input  logic [W-1:0] dual,     // 1 = both edges
   input  logic [W-1:0] pol,      // 1 = rising / high
   input  logic [W-1:0] clr,      // write-1-to-clear pulse
   output logic [W-1:0] status
);

   logic [W-1:0] prev;
   logic [W-1:0] rise, fall, edge_ev, lvl_ev, ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= s;
   end

   assign rise    = s & ~prev;
   assign fall    = ~s & prev;
   assign edge_ev = (dual & (rise | fall)) | (~dual & pol & rise) | (~dual & ~pol & fall);
   assign lvl_ev  = ~(s ^ pol);
   assign ev      = (lvl_sel & lvl_ev) | (~lvl_sel & edge_ev);

   // A new event wins over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | ev;
   end

   AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((~lvl_sel & ~dual & ((pol & rise) | (~pol & fall))) != '0) |=>
      ((status & $past(~lvl_sel & ~dual & ((pol & rise) | (~pol & fall))))
         == $past(~lvl_sel & ~dual & ((pol & rise) | (~pol & fall))))); // R4

   AST_DUAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((~lvl_sel & dual & (s ^ prev)) != '0) |=>
      ((status & $past(~lvl_sel & dual & (s ^ prev))) == $past(~lvl_sel & dual & (s ^ prev)))); // R5

   AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((lvl_sel & ~(s ^ pol)) != '0) |=>
      ((status & $past(lvl_sel & ~(s ^ pol))) == $past(lvl_sel & ~(s ^ pol)))); // R6

   AST_CLEAR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      ((~status & $past(status) & ~$past(clr)) == '0)); // R8

endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int W           = 32,
   parameter int OFF_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             we,
   input  logic [OFF_W-1:0] off,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata,
   input  logic [W-1:0]     pin_in,
   output logic [W-1:0]     pin_out,
   output logic [W-1:0]     pin_oe,
   output logic             pend
);

   reg_sel_e     rsel;
   logic         wr_en;
   logic [W-1:0] din, dout, oe, lvl_sel, dual, pol, mask, clr, raw, mstat;

   assign rsel  = decode_off(int'(off));
   assign wr_en = sel & we;

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (din)
   );

   // Input data, raw and masked status are not write targets.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         oe      <= '0;
         lvl_sel <= '0;
         dual    <= '0;
         pol     <= '0;
         mask    <= '0;
      end else if (wr_en) begin
         case (rsel)
            SEL_DOUT: dout    <= wdata;
            SEL_OE:   oe      <= wdata;
            SEL_LVL:  lvl_sel <= wdata;
            SEL_DUAL: dual    <= wdata;
            SEL_POL:  pol     <= wdata;
            SEL_MASK: mask    <= wdata;
            default:  ;
         endcase
      end
   end

   assign clr = (wr_en && rsel == SEL_CLR) ? wdata : '0;

   gpio_irq_detect #(.W(W)) i_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .s       (din),
      .lvl_sel (lvl_sel),
      .dual    (dual),
      .pol     (pol),
      .clr     (clr),
      .status  (raw)
   );

   assign mstat   = raw & mask;
   assign pend    = |mstat;
   assign pin_oe  = oe;
   assign pin_out = dout & oe;

   always_comb begin
      case (rsel)
         SEL_DIN:   rdata = din;
         SEL_DOUT:  rdata = dout;
         SEL_OE:    rdata = oe;
         SEL_LVL:   rdata = lvl_sel;
         SEL_DUAL:  rdata = dual;
         SEL_POL:   rdata = pol;
         SEL_MASK:  rdata = mask;
         SEL_RAW:   rdata = raw;
         SEL_MSTAT: rdata = mstat;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_banks.sv
`timescale 1ns/1ps
module gpio_irq_banks #(
   parameter int NUM_BANKS     = 2,
   parameter int PINS_PER_BANK = 32,
   parameter int BANK_STRIDE   = 512,
   parameter int SYNC_STAGES   = 2,
   parameter int ADDR_W        = 10
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic                               bus_we,
   input  logic [PINS_PER_BANK-1:0]           bus_wdata,
   output logic [PINS_PER_BANK-1:0]           bus_rdata,
   input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_in,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_out,
   output logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_oe,
   output logic                               irq_out
);

   localparam int W      = PINS_PER_BANK;
   localparam int OFF_W  = $clog2(BANK_STRIDE);
   localparam int BIDX_W = ADDR_W - OFF_W;

   initial begin : p_param
      assert (NUM_BANKS >= 1) else $error("gpio_irq_banks: NUM_BANKS < 1");
      assert (W == 32) else $error("gpio_irq_banks: PINS_PER_BANK must be 32");
      assert ((1 << OFF_W) == BANK_STRIDE && BANK_STRIDE >= 64)
         else $error("gpio_irq_banks: BANK_STRIDE must be a power of two >= 64");
      assert (BIDX_W >= 1 && NUM_BANKS <= (1 << BIDX_W))
         else $error("gpio_irq_banks: ADDR_W too small for NUM_BANKS");
   end

   logic [BIDX_W-1:0]    bidx;
   logic [OFF_W-1:0]     boff;
   logic [W-1:0]         bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_pend;
   logic                 irq_q;

   assign bidx = bus_addr[ADDR_W-1:OFF_W];
   assign boff = bus_addr[OFF_W-1:0];

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         gpio_bank #(.W(W), .OFF_W(OFF_W), .SYNC_STAGES(SYNC_STAGES)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (bidx == BIDX_W'(b)),
            .we      (bus_we),
            .off     (boff),
            .wdata   (bus_wdata),
            .rdata   (bank_rd[b]),
            .pin_in  (pin_in[b*W +: W]),
            .pin_out (pin_out[b*W +: W]),
            .pin_oe  (pin_oe[b*W +: W]),
            .pend    (bank_pend[b])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (bidx == BIDX_W'(i)) bus_rdata = bank_rd[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |bank_pend;
   end

   assign irq_out = irq_q;

   AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(|bank_pend)); // R9

endmodule

// File: tb/test_gpio_irq_banks.sv
`timescale 1ns/1ps
module test_gpio_irq_banks;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] pins = '0;
   logic [63:0] pout, poe;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk; // 200 MHz

   gpio_irq_banks i_gpio_irq_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .pin_in    (pins),
      .pin_out   (pout),
      .pin_oe    (poe),
      .irq_out   (irq)
   );

   // {addr, write data, expected read, requirement number}
   localparam logic [77:0] TBL [9] = '{
      {10'h004, 32'h1234_5678, 32'h1234_5678, 4'd2},
      {10'h008, 32'h0000_FFFF, 32'h0000_FFFF, 4'd2},
      {10'h204, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'd2},
      {10'h208, 32'hFFFF_0000, 32'hFFFF_0000, 4'd2},
      {10'h000, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3},
      {10'h01C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd7},
      {10'h020, 32'hFFFF_FFFF, 32'h0000_0000, 4'd7},
      {10'h024, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},
      {10'h018, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 4'd7}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] v);
      addr = a;
      #0.5;
      v = rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pin(input int n, input logic v);
      @(negedge clk);
      pins[n] = v;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin : watchdog
      #500us;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      // R1: reset state
      step(3);
      rd(10'h004, v); chk("R1 dout in reset", v, 0);
      rd(10'h018, v); chk("R1 mask in reset", v, 0);
      chk("R1 pin_oe in reset", poe, 0);
      chk("R1 irq in reset", irq, 0);
      rst_n = 1'b1;
      step(2);
      rd(10'h01C, v); chk("R1 raw after reset", v, 0);
      rd(10'h208, v); chk("R1 bank1 oe after reset", v, 0);

      // Table of write/readback vectors
      for (int i = 0; i < 9; i++) begin
         wr(TBL[i][77:68], TBL[i][67:36]);
         rd(TBL[i][77:68], v);
         chk($sformatf("R%0d table entry %0d", TBL[i][3:0], i), v, TBL[i][35:4]);
      end
      chk("R2 pin_out gated by enable", pout, 64'hCAFE_0000_0000_5678);
      chk("R2 pin_oe", poe, 64'hFFFF_0000_0000_FFFF);

      wr(10'h018, 0);
      wr(10'h024, 32'hFFFF_FFFF);

      // R3: two-stage synchronizer on input data
      pin(3, 1'b1);
      step(1); rd(10'h000, v); chk("R3 din after one edge", v, 0);
      step(1); rd(10'h000, v); chk("R3 din after two edges", v, 32'h8);

      // R4: rising edge on pin 5
      wr(10'h014, 32'h20);
      wr(10'h018, 32'h20);
      wr(10'h024, 32'hFFFF_FFFF);
      pin(5, 1'b1);
      step(2); rd(10'h01C, v); chk("R4 raw not yet", v & 32'h20, 0);
      step(1); rd(10'h01C, v); chk("R4 rising sets raw", v & 32'h20, 32'h20);
      chk("R9 irq not yet", irq, 0);
      step(1); chk("R9 irq one edge later", irq, 1);
      rd(10'h020, v); chk("R7 masked status", v, 32'h20);
      wr(10'h024, 32'h0);
      rd(10'h01C, v); chk("R8 zero clear no effect", v & 32'h20, 32'h20);
      wr(10'h024, 32'h20);
      rd(10'h01C, v); chk("R8 clear bit", v & 32'h20, 0);
      chk("R9 irq holds one edge", irq, 1);
      step(1); chk("R9 irq drops", irq, 0);
      pin(5, 1'b0);
      step(4); rd(10'h01C, v); chk("R4 falling ignored in rising mode", v & 32'h20, 0);

      // R4: falling edge on pin 6 (polarity 0)
      pin(6, 1'b1);
      step(4); rd(10'h01C, v); chk("R4 rising ignored in falling mode", v & 32'h40, 0);
      pin(6, 1'b0);
      step(3); rd(10'h01C, v); chk("R4 falling sets raw", v & 32'h40, 32'h40);

      // R5: dual edge on pin 7 with polarity rising
      wr(10'h014, 32'h1A0);
      wr(10'h010, 32'h80);
      pin(7, 1'b1);
      step(3); rd(10'h01C, v); chk("R5 dual rising", v & 32'h80, 32'h80);
      wr(10'h024, 32'h80);
      pin(7, 1'b0);
      step(3); rd(10'h01C, v); chk("R5 dual falling", v & 32'h80, 32'h80);

      // R6: level high on pin 8
      wr(10'h00C, 32'h100);
      pin(8, 1'b1);
      step(3); rd(10'h01C, v); chk("R6 level high sets", v & 32'h100, 32'h100);
      wr(10'h024, 32'h100);
      rd(10'h01C, v); chk("R6 clear does not stick while active", v & 32'h100, 32'h100);
      pin(8, 1'b0);
      step(3);
      wr(10'h024, 32'h100);
      rd(10'h01C, v); chk("R6 clear after level inactive", v & 32'h100, 0);

      // R6: level low on pin 9 (pin already low)
      wr(10'h00C, 32'h300);
      step(1); rd(10'h01C, v); chk("R6 level low sets", v & 32'h200, 32'h200);

      // R7: masked view and read-only status
      wr(10'h024, 32'hFFFF_FFFF);
      rd(10'h01C, v); chk("R8 clear all but active level", v, 32'h200);
      wr(10'h018, 32'h300);
      rd(10'h020, v); chk("R7 masked includes enabled", v, 32'h200);
      wr(10'h018, 32'h100);
      rd(10'h020, v); chk("R7 masked excludes disabled", v, 0);
      wr(10'h01C, 32'hFFFF_FFFF);
      wr(10'h020, 32'hFFFF_FFFF);
      rd(10'h01C, v); chk("R7 raw write ignored", v, 32'h200);
      step(1); chk("R9 irq off when nothing enabled", irq, 0);

      // R10: bank 1, pin 40 = bank1 bit 8
      wr(10'h018, 0);
      wr(10'h214, 32'h100);
      wr(10'h218, 32'h100);
      wr(10'h224, 32'hFFFF_FFFF);
      pin(40, 1'b1);
      step(3);
      rd(10'h21C, v); chk("R10 bank1 raw bit 8", v, 32'h100);
      rd(10'h200, v); chk("R10 bank1 din", v, 32'h100);
      rd(10'h01C, v); chk("R10 bank0 raw untouched", v, 32'h200);
      step(1); chk("R9 irq from bank1", irq, 1);

      // R1: reset again, mid-operation
      @(negedge clk); rst_n = 1'b0;
      #0.5;
      rd(10'h21C, v); chk("R1 bank1 raw cleared", v, 0);
      rd(10'h004, v); chk("R1 dout cleared", v, 0);
      chk("R1 irq cleared", irq, 0);
      chk("R1 pin_oe cleared", poe, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule